// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Sequencer

This block is a very small stored-program machine built around one 16-bit accumulator. It reads instruction words from a word-addressed synchronous memory. Each word is handled in two phases. In the fetch phase the word at the program counter is brought into the instruction register and the counter steps by one. In the execute phase the opcode is decoded and the operand word is read or written.

The machine knows three operations: load the accumulator from memory, add a memory word to the accumulator, and write the accumulator back to memory. Every other opcode stops the machine. The memory port is a single port with a registered address, write data and write enable, and its read data arrives one cycle after the address. After reset the machine waits for a start strobe. The strobe copies the start address into the program counter. From then on the machine runs words in increasing address order until it meets an opcode it does not know, and then it raises a halt flag that stays up. The program counter, the instruction register and the accumulator are brought out so that the surrounding logic can check them.

Top module: `acc_cpu_top`

## Requirements
- R1: Reset sets pc, ir, acc and mem_we to zero and halted low. Until start is seen high, the machine stays idle and writes nothing to memory.
- R2: A start pulse seen while idle loads start_addr into pc, and the first fetch reads that address. A start pulse seen while running has no effect on the program's results.
- R3: An instruction word carries its opcode in bits 15:12 and the absolute operand address in bits 11:0.
- R4: Opcode 1 copies the addressed memory word into acc.
- R5: Opcode 5 adds the addressed memory word to acc, modulo 2^16, and keeps no flags.
- R6: Opcode 2 writes acc into the addressed memory word with a one-cycle mem_we pulse, and the write data equals acc.
- R7: Each fetch advances pc by exactly one, and instructions run in increasing address order.
- R8: Any opcode other than 1, 2 or 5 sets halted. Halted stays set until reset. After that the machine makes no further fetch or write, acc is left unchanged, and pc stays one past the offending word.
- R9: Counted from the start cycle as cycle 1, a load or an add takes 5 cycles, a store takes 4, and halted rises 3 cycles after the fetch of the unknown word begins.
- R10: The worked program runs as follows. The memory holds 0x300=0x1940, 0x301=0x5941, 0x302=0x2941, 0x303=0x0000, 0x940=0x0003 and 0x941=0x0002. The program ends with acc=0x0005, memory 0x941=0x0005 and pc=0x304.
- R11: After a halt, ir holds the last word that was fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run strobe, sampled only while idle |
| start_addr | input | 12 | Address of the first instruction |
| mem_addr | output | 12 | Registered memory word address |
| mem_wdata | output | 16 | Registered memory write data |
| mem_we | output | 1 | Registered memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| halted | output | 1 | Sticky stop indication |
| pc | output | 12 | Program counter |
| ir | output | 16 | Instruction register |
| acc | output | 16 | Accumulator |

## Verification
The bench builds the block with its default values: a 16-bit data word and a 12-bit address. With these values the whole 4-bit opcode space can be swept one opcode at a time, and the worked program runs at its real addresses. Operand pairs taken from a set of edge values (0, 1, 0x7FFF, 0x8000, 0xFFFE, 0xFFFF and others) exercise every wrap of the 16-bit adder. The bench predicts the exact cycle count of each run from the per-instruction cost and checks it.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd1;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'd2;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'd5;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FADDR,
    PH_FDATA,
    PH_EXEC,
    PH_OADDR,
    PH_ODATA,
    PH_WRITE,
    PH_HALT
  } phase_e;

  typedef enum logic [1:0] {
    AS_KEEP,
    AS_START,
    AS_OPND,
    AS_PC
  } addr_sel_e;

  typedef enum logic [1:0] {
    AO_NONE,
    AO_LOAD,
    AO_ADD
  } acc_op_e;

  typedef struct packed {
    logic is_load;
    logic is_store;
    logic is_add;
    logic is_bad;
  } dec_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic [DATA_W-1:0] instr,
  output dec_t              dec,
  output logic [ADDR_W-1:0] opnd_addr
);

  localparam int OPC_LSB = DATA_W - OPC_W;

  logic [OPC_W-1:0] opc;

  assign opc       = instr[DATA_W-1:OPC_LSB];
  assign opnd_addr = instr[ADDR_W-1:0];

  always_comb begin
    dec = '0;
    case (opc)
      OPC_LOAD:  dec.is_load  = 1'b1;
      OPC_STORE: dec.is_store = 1'b1;
      OPC_ADD:   dec.is_add   = 1'b1;
      default:   dec.is_bad   = 1'b1;
    endcase
  end

  // R3: exactly one class is picked for every opcode
  always_comb begin
    a_r3_one_class: assert ($countones(dec) == 1);
  end

endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_cpu_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  dec_t      dec,
  output phase_e    phase,
  output logic      halted,
  output addr_sel_e addr_sel,
  output logic      set_we,
  output logic      ir_cap,
  output acc_op_e   acc_op
);

  phase_e phase_nxt;
  logic   halt_set;

  always_comb begin
    phase_nxt = phase;
    addr_sel  = AS_KEEP;
    set_we    = 1'b0;
    ir_cap    = 1'b0;
    acc_op    = AO_NONE;
    halt_set  = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (start) begin
          addr_sel  = AS_START;
          phase_nxt = PH_FADDR;
        end
      end
      PH_FADDR: phase_nxt = PH_FDATA;
      PH_FDATA: begin
        ir_cap    = 1'b1;
        phase_nxt = PH_EXEC;
      end
      PH_EXEC: begin
        if (dec.is_bad) begin
          halt_set  = 1'b1;
          phase_nxt = PH_HALT;
        end else begin
          addr_sel = AS_OPND;
          if (dec.is_store) begin
            set_we    = 1'b1;
            phase_nxt = PH_WRITE;
          end else begin
            phase_nxt = PH_OADDR;
          end
        end
      end
      PH_OADDR: phase_nxt = PH_ODATA;
      PH_ODATA: begin
        acc_op    = dec.is_add ? AO_ADD : AO_LOAD;
        addr_sel  = AS_PC;
        phase_nxt = PH_FADDR;
      end
      PH_WRITE: begin
        addr_sel  = AS_PC;
        phase_nxt = PH_FADDR;
      end
      default: phase_nxt = phase;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      halted <= 1'b0;
    end else begin
      phase <= phase_nxt;
      if (halt_set) halted <= 1'b1;
    end
  end

  // R8: once stopped, the machine stays stopped
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R8: the stop flag and the stop phase agree
  a_r8_halt_phase: assert property (@(posedge clk) disable iff (rst)
    halted |-> phase == PH_HALT);

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  addr_sel_e         addr_sel,
  input  logic              set_we,
  input  logic              ir_cap,
  input  acc_op_e           acc_op,
  input  logic              halted,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] opnd_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      ir        <= '0;
      acc       <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
    end else begin
      mem_we <= set_we;
      if (set_we) mem_wdata <= acc;
      case (addr_sel)
        AS_START: begin
          mem_addr <= start_addr;
          pc       <= start_addr;
        end
        AS_OPND: mem_addr <= opnd_addr;
        AS_PC:   mem_addr <= pc;
        default: ;
      endcase
      if (ir_cap) begin
        ir <= mem_rdata;
        pc <= pc + ADDR_W'(1);
      end
      case (acc_op)
        AO_LOAD: acc <= mem_rdata;
        AO_ADD:  acc <= acc + mem_rdata;
        default: ;
      endcase
    end
  end

  // R6: a write lasts one cycle
  a_r6_we_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R6: the written value is the accumulator
  a_r6_wdata_acc: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata == acc);

  // R8: program counter frozen after stop
  a_r8_pc_frozen: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc));

  // R8: accumulator frozen after stop
  a_r8_acc_frozen: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(acc));

endmodule

// File: rtl/acc_cpu_top.sv
module acc_cpu_top
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] acc
);

  dec_t              dec;
  logic [ADDR_W-1:0] opnd_addr;
  phase_e            phase;
  addr_sel_e         addr_sel;
  logic              set_we;
  logic              ir_cap;
  acc_op_e           acc_op;

  acc_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .instr     (ir),
    .dec       (dec),
    .opnd_addr (opnd_addr)
  );

  acc_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .dec      (dec),
    .phase    (phase),
    .halted   (halted),
    .addr_sel (addr_sel),
    .set_we   (set_we),
    .ir_cap   (ir_cap),
    .acc_op   (acc_op)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .addr_sel   (addr_sel),
    .set_we     (set_we),
    .ir_cap     (ir_cap),
    .acc_op     (acc_op),
    .halted     (halted),
    .start_addr (start_addr),
    .opnd_addr  (opnd_addr),
    .mem_rdata  (mem_rdata),
    .pc         (pc),
    .ir         (ir),
    .acc        (acc),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we)
  );

  // R8: no memory write while stopped
  a_r8_no_write_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  // R1: no memory write while waiting for the first start
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    phase == PH_IDLE |-> !mem_we);

endmodule

// File: tb/tb_acc_cpu_top.sv
module tb_acc_cpu_top;

  localparam int DW = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata = '0;
  logic          halted;
  logic [AW-1:0] pc;
  logic [DW-1:0] ir;
  logic [DW-1:0] acc;

  logic [DW-1:0] mem [0:(1<<AW)-1];

  int nchk = 0;
  int nerr = 0;
  int ncyc = 0;

  always #2.5 clk = ~clk;

  acc_cpu_top #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .halted(halted), .pc(pc), .ir(ir), .acc(acc)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input logic [AW-1:0] sa, input bit repulse, output int cyc);
    @(negedge clk);
    start_addr = sa;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!halted && cyc < 5000) begin
      if (repulse && cyc == 3) begin
        start = 1'b1;
        start_addr = '0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
  endtask

  function automatic logic [DW-1:0] edge_val(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      5: return 16'h1234;
      6: return 16'hFFFE;
      default: return 16'h00FF;
    endcase
  endfunction

  task automatic worked(input bit repulse, input string tag);
    int cyc;
    clear_mem();
    do_reset();
    mem[12'h300] = 16'h1940;
    mem[12'h301] = 16'h5941;
    mem[12'h302] = 16'h2941;
    mem[12'h303] = 16'h0000;
    mem[12'h940] = 16'h0003;
    mem[12'h941] = 16'h0002;
    run(12'h300, repulse, cyc);
    chk({tag, " acc"}, 32'(acc), 32'h0005);
    chk({tag, " mem941"}, 32'(mem[12'h941]), 32'h0005);
    chk({tag, " pc"}, 32'(pc), 32'h304);
    chk({tag, " R11 ir"}, 32'(ir), 32'h0000);
    chk({tag, " R9 cycles"}, 32'(cyc), 32'd18);
  endtask

  initial begin
    int cyc;
    logic [DW-1:0] a, b, e;
    clear_mem();
    do_reset();

    // R1: reset state and idle without start
    chk("R1 pc", 32'(pc), 0);
    chk("R1 ir", 32'(ir), 0);
    chk("R1 acc", 32'(acc), 0);
    chk("R1 halted", 32'(halted), 0);
    chk("R1 mem_we", 32'(mem_we), 0);
    repeat (6) @(negedge clk);
    chk("R1 idle pc", 32'(pc), 0);
    chk("R1 idle halted", 32'(halted), 0);

    // R10: worked program; R2 start and restart ignored
    worked(1'b0, "R10");
    worked(1'b1, "R2 restart");

    // R3/R4/R5/R6/R8: sweep of the whole opcode space
    for (int op = 0; op < 16; op++) begin
      clear_mem();
      do_reset();
      mem[12'h010] = ins(4'd1, 12'h800);
      mem[12'h011] = ins(4'(op), 12'h801);
      mem[12'h012] = 16'hE000;
      mem[12'h800] = 16'h1234;
      mem[12'h801] = 16'h0F0F;
      run(12'h010, 1'b0, cyc);
      chk("R8 halted", 32'(halted), 1);
      case (op)
        1: begin
          chk("R4 load acc", 32'(acc), 32'h0F0F);
          chk("R7 pc", 32'(pc), 32'h013);
          chk("R9 load cycles", 32'(cyc), 32'd14);
        end
        5: begin
          chk("R5 add acc", 32'(acc), 32'h2143);
          chk("R7 pc", 32'(pc), 32'h013);
          chk("R9 add cycles", 32'(cyc), 32'd14);
        end
        2: begin
          chk("R6 store mem", 32'(mem[12'h801]), 32'h1234);
          chk("R6 store acc", 32'(acc), 32'h1234);
          chk("R9 store cycles", 32'(cyc), 32'd13);
        end
        default: begin
          chk("R8 acc kept", 32'(acc), 32'h1234);
          chk("R8 pc", 32'(pc), 32'h012);
          chk("R8 mem kept", 32'(mem[12'h801]), 32'h0F0F);
          chk("R11 ir", 32'(ir), 32'(ins(4'(op), 12'h801)));
          chk("R9 halt cycles", 32'(cyc), 32'd9);
        end
      endcase
      repeat (4) @(negedge clk);
      chk("R8 sticky", 32'(halted), 1);
    end

    // R5/R6: wrap sweep over edge value pairs
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        a = edge_val(i);
        b = edge_val(j);
        e = DW'(32'(a) + 32'(b));
        clear_mem();
        do_reset();
        mem[12'h000] = ins(4'd1, 12'hA00);
        mem[12'h001] = ins(4'd5, 12'hA01);
        mem[12'h002] = ins(4'd2, 12'hFFF);
        mem[12'h003] = 16'hF000;
        mem[12'hA00] = a;
        mem[12'hA01] = b;
        run(12'h000, 1'b0, cyc);
        chk("R5 wrap acc", 32'(acc), 32'(e));
        chk("R6 wrap mem", 32'(mem[12'hFFF]), 32'(e));
      end
    end

    // R7: long straight-line run of adds from a reset accumulator
    clear_mem();
    do_reset();
    e = '0;
    for (int k = 0; k < 20; k++) begin
      mem[12'h100 + 12'(k)] = ins(4'd5, 12'h900 + 12'(k));
      mem[12'h900 + 12'(k)] = DW'(k * 16'h0ABC + 7);
      e = e + DW'(k * 16'h0ABC + 7);
    end
    mem[12'h114] = 16'h3000;
    run(12'h100, 1'b0, cyc);
    chk("R7 sum", 32'(acc), 32'(e));
    chk("R7 pc", 32'(pc), 32'h115);
    chk("R9 run cycles", 32'(cyc), 32'd104);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule